// File: doc/BRIEF.md
# Overflow Status Timeout Multiplexer

The block reports clipping in a two-channel audio capture path on a single status line. The converter datapath delivers a one-clock overrange strobe per channel. The block keeps a sticky flag for each channel. A strobe sets its channel's flag at once. Both flags are cleared together once a shared, retriggerable timeout expires, and any new strobe on either channel restarts that timeout.

The two flags are time-multiplexed onto one active-low line. The line follows the serial audio port's frame clock and bit clock, so a receiver can separate the two channels by latching the line on the frame clock edges. After each frame clock transition the line is updated after a delay that depends on the serial format. The output models an open-drain pin: an enable pulls the pin low while the slotted flag is set.

The timeout is counted in frame clock periods. The count doubles at double speed and doubles again at quad speed, so the hold time in milliseconds stays the same. The frame and bit clocks are level inputs sampled by the block clock `clk_i`.

Top module: `ovfl_tdm`

## Requirements
- R1: While `rst_ni` is low, and until the first slot update after reset, `ovfl_oe_o` is 0 and `ovfl_n_o` is 1. Both channel flags are clear.
- R2: An overrange strobe (`ovr_l_i` for left, `ovr_r_i` for right) sets that channel's flag on the next clock. The flag appears at that channel's next output slot.
- R3: A strobe on either channel restarts the shared timeout for both flags. A flag set earlier therefore stays set past the time at which it would otherwise have cleared.
- R4: With no further strobes, both flags clear together on the 2^(TMO_LOG2+k)-th rising frame clock edge after the last strobe. k is 0, 1 and 2 for `speed_i` codes 0 (single), 1 (double) and 2 (quad). Code 3 behaves as code 2.
- R5: With `fmt_i2s_i`=0, the line is updated on the first bit clock falling edge after a frame clock transition. With `fmt_i2s_i`=1, it is updated on the second such edge. The new value is visible one clock after the clock that samples that edge.
- R6: With `fmt_i2s_i`=0, the right flag is carried while the frame clock is low (latched at its rising edge) and the left flag while it is high (latched at its falling edge). With `fmt_i2s_i`=1, the left flag is carried while the frame clock is low and the right flag while it is high.
- R7: `ovfl_oe_o` changes only in the clock that follows a sampled bit clock falling edge.
- R8: `ovfl_n_o` is always the complement of `ovfl_oe_o` (active low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; samples all other inputs |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial bit clock level |
| lrck_i | input | 1 | Serial frame clock level |
| fmt_i2s_i | input | 1 | 0 = left-justified timing, 1 = I2S timing |
| speed_i | input | 2 | 0 single, 1 double, 2 quad, 3 treated as quad |
| ovr_l_i | input | 1 | Left channel overrange strobe |
| ovr_r_i | input | 1 | Right channel overrange strobe |
| ovfl_n_o | output | 1 | Pin level seen with an external pull-up, low = overflow |
| ovfl_oe_o | output | 1 | Open-drain pull-down enable |

## Verification
The assertions assume that `sclk_i` and `lrck_i` are synchronous to `clk_i`, and that each frame clock transition coincides with a bit clock falling edge. They also assume many bit clocks per frame half, so a slot update always finishes before the next frame edge. The stimulus generates the bit clock as four block clocks per period, with 32 bit clocks per frame half. It changes the format and speed codes only while reset is held. Strobes are placed just after a frame clock edge, so each directed latch check sees the effect of a whole slot.

// File: rtl/ovfl_tdm_pkg.sv
package ovfl_tdm_pkg;
  localparam int unsigned NCH = 2;           // index 0 left, 1 right
  localparam logic [1:0] LEAD_LJ  = 2'd1;    // bit clock falls before update
  localparam logic [1:0] LEAD_I2S = 2'd2;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2,
    SPD_RSVD   = 2'd3
  } speed_e;

  function automatic int unsigned speed_shift(input logic [1:0] code);
    case (speed_e'(code))
      SPD_SINGLE: return 0;
      SPD_DOUBLE: return 1;
      default:    return 2;
    endcase
  endfunction
endpackage

// File: rtl/ovfl_edge_det.sv
module ovfl_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic lrck_i,
  output logic sclk_fall_o,
  output logic lrck_edge_o,
  output logic lrck_rise_o,
  output logic lrck_lvl_o
);
  logic sclk_q, lrck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      lrck_q <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      lrck_q <= lrck_i;
    end
  end

  assign sclk_fall_o = sclk_q & ~sclk_i;
  assign lrck_edge_o = lrck_q ^ lrck_i;
  assign lrck_rise_o = lrck_i & ~lrck_q;
  assign lrck_lvl_o  = lrck_i;
endmodule

// File: rtl/ovfl_hold_timer.sv
module ovfl_hold_timer
  import ovfl_tdm_pkg::*;
#(
  parameter int unsigned TMO_LOG2 = 15,
  localparam int unsigned CW = TMO_LOG2 + 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] set_i,
  input  logic           tick_i,
  input  logic [1:0]     speed_i,
  output logic [NCH-1:0] flags_o,
  output logic [CW-1:0]  cnt_o
);
  logic [CW-1:0] cnt_q;
  logic [CW:0]   span;
  logic          hit, active, at_end, expire;

  assign span   = (CW+1)'(1) << (TMO_LOG2 + speed_shift(speed_i));
  assign hit    = |set_i;
  assign active = |flags_o;
  assign at_end = ({1'b0, cnt_q} == span - (CW+1)'(1));
  assign expire = tick_i & at_end & active & ~hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (hit || expire)     cnt_q <= '0;
    else if (active && tick_i)  cnt_q <= cnt_q + CW'(1);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flags_o[c] <= 1'b0;
      else if (set_i[c]) flags_o[c] <= 1'b1;
      else if (expire)   flags_o[c] <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ovfl_slot_mux.sv
module ovfl_slot_mux
  import ovfl_tdm_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sclk_fall_i,
  input  logic           lrck_edge_i,
  input  logic           lrck_lvl_i,
  input  logic           fmt_i2s_i,
  input  logic [NCH-1:0] flags_i,
  output logic           slot_o
);
  logic [1:0] wait_q;
  logic       pick_right;

  // LJ: low half carries right; I2S: low half carries left
  assign pick_right = (lrck_lvl_i == fmt_i2s_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= '0;
      slot_o <= 1'b0;
    end else if (lrck_edge_i) begin
      wait_q <= fmt_i2s_i ? LEAD_I2S : LEAD_LJ;
    end else if (sclk_fall_i && wait_q != 2'd0) begin
      wait_q <= wait_q - 2'd1;
      if (wait_q == 2'd1) slot_o <= pick_right ? flags_i[1] : flags_i[0];
    end
  end
endmodule

// File: rtl/ovfl_tdm.sv
module ovfl_tdm
  import ovfl_tdm_pkg::*;
#(
  parameter int unsigned TMO_LOG2 = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       lrck_i,
  input  logic       fmt_i2s_i,
  input  logic [1:0] speed_i,
  input  logic       ovr_l_i,
  input  logic       ovr_r_i,
  output logic       ovfl_n_o,
  output logic       ovfl_oe_o
);
  localparam int unsigned CW = TMO_LOG2 + 2;

  logic           sclk_fall, lrck_edge, lrck_rise, lrck_lvl, slot;
  logic [NCH-1:0] flags;
  logic [CW-1:0]  tmo_cnt;

  ovfl_edge_det u_edge (
    .clk_i, .rst_ni, .sclk_i, .lrck_i,
    .sclk_fall_o(sclk_fall), .lrck_edge_o(lrck_edge),
    .lrck_rise_o(lrck_rise), .lrck_lvl_o(lrck_lvl)
  );

  ovfl_hold_timer #(.TMO_LOG2(TMO_LOG2)) u_tmo (
    .clk_i, .rst_ni,
    .set_i({ovr_r_i, ovr_l_i}), .tick_i(lrck_rise), .speed_i,
    .flags_o(flags), .cnt_o(tmo_cnt)
  );

  ovfl_slot_mux u_slot (
    .clk_i, .rst_ni,
    .sclk_fall_i(sclk_fall), .lrck_edge_i(lrck_edge), .lrck_lvl_i(lrck_lvl),
    .fmt_i2s_i, .flags_i(flags), .slot_o(slot)
  );

  assign ovfl_oe_o = slot;
  assign ovfl_n_o  = ~slot;
endmodule

// File: rtl/ovfl_tdm_chk.sv
module ovfl_tdm_chk #(
  parameter int unsigned CW = 17
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sclk_i,
  input logic          ovr_l_i,
  input logic          ovr_r_i,
  input logic          ovfl_oe_o,
  input logic [1:0]    flags_i,
  input logic [CW-1:0] cnt_i
);
  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_idle_r1: assert (!ovfl_oe_o && flags_i == 2'b00);
  end

  p_set_left_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_l_i |=> flags_i[0]);
  p_set_right_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_r_i |=> flags_i[1]);
  p_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_l_i || ovr_r_i) |=> (cnt_i == '0));
  p_joint_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flags_i[0]) |-> !flags_i[1]);
  p_slot_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($past(sclk_i, 2) && !$past(sclk_i)) |-> $stable(ovfl_oe_o));
endmodule

bind ovfl_tdm ovfl_tdm_chk #(.CW(CW)) u_chk (
  .clk_i, .rst_ni, .sclk_i, .ovr_l_i, .ovr_r_i, .ovfl_oe_o,
  .flags_i(flags), .cnt_i(tmo_cnt)
);

// File: tb/ovfl_tdm_test.sv
`timescale 1ns/1ps
module ovfl_tdm_test;
  localparam int TL = 2;

  logic clk = 0, rst_n = 0, sclk = 1, lrck = 0, fmt = 0;
  logic [1:0] spd = 0;
  logic ovr_l = 0, ovr_r = 0;
  logic ovfl_n, ovfl_oe;
  int checks = 0, fails = 0;
  bit lat_l = 0, lat_r = 0;
  event ev_rise, ev_fall;

  always #2.5 clk = ~clk;

  ovfl_tdm #(.TMO_LOG2(TL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .lrck_i(lrck),
    .fmt_i2s_i(fmt), .speed_i(spd), .ovr_l_i(ovr_l), .ovr_r_i(ovr_r),
    .ovfl_n_o(ovfl_n), .ovfl_oe_o(ovfl_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // serial clocks: 4 clk per bit clock, 32 bit clocks per frame half; receiver latch
  int ph = 0, bitc = 0;
  always @(negedge clk) begin
    ph = (ph + 1) % 4;
    if (ph == 0) sclk = 1;
    else if (ph == 2) begin
      sclk = 0;
      bitc++;
      if (bitc == 32) begin
        bitc = 0;
        if (!lrck) begin if (!fmt) lat_r = !ovfl_n; else lat_l = !ovfl_n; end
        else       begin if (!fmt) lat_l = !ovfl_n; else lat_r = !ovfl_n; end
        lrck = !lrck;
        if (lrck) -> ev_rise; else -> ev_fall;
      end
    end
  end

  // behavioural reference
  bit m_fl, m_fr, m_out, m_sq, m_lq;
  int m_cnt, m_rem;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fl = 0; m_fr = 0; m_out = 0; m_sq = 0; m_lq = 0; m_cnt = 0; m_rem = 0;
    end else begin
      bit fall, edg, rise;
      int lim;
      fall = m_sq && !sclk;
      edg  = (lrck != m_lq);
      rise = lrck && !m_lq;
      lim  = 1 << (TL + ((spd == 3) ? 2 : int'(spd)));
      if (edg) m_rem = fmt ? 2 : 1;
      else if (fall && m_rem > 0) begin
        m_rem--;
        if (m_rem == 0) m_out = (lrck == fmt) ? m_fr : m_fl;
      end
      if (ovr_l || ovr_r) begin
        if (ovr_l) m_fl = 1;
        if (ovr_r) m_fr = 1;
        m_cnt = 0;
      end else if ((m_fl || m_fr) && rise) begin
        m_cnt++;
        if (m_cnt == lim) begin m_fl = 0; m_fr = 0; m_cnt = 0; end
      end
      m_sq = sclk; m_lq = lrck;
    end
  end

  always @(negedge clk) begin
    if (rst_n) chk(ovfl_oe === m_out && ovfl_n === !m_out,
                   "R5 R6 R7 R8 model", {ovfl_n, ovfl_oe}, {!m_out, m_out});
  end

  task automatic pulse(input bit l, input bit r);
    @(negedge clk); ovr_l = l; ovr_r = r;
    @(negedge clk); ovr_l = 0; ovr_r = 0;
  endtask

  task automatic restart(input bit f, input logic [1:0] s);
    @(negedge clk); rst_n = 0; fmt = f; spd = s;
    repeat (3) @(negedge clk);
    chk(ovfl_oe == 0 && ovfl_n == 1, "R1 reset", {ovfl_n, ovfl_oe}, 2);
    rst_n = 1;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(ovfl_oe == 0 && ovfl_n == 1, "R1 reset", {ovfl_n, ovfl_oe}, 2);
    rst_n = 1;

    // A: left-justified, single speed, right channel
    @(ev_rise); repeat (3) @(negedge clk); pulse(0, 1);
    @(ev_fall); repeat (4) @(negedge clk);
    chk(ovfl_oe == 0, "R5 LJ before first fall", ovfl_oe, 0);
    @(negedge clk);
    chk(ovfl_oe == 1, "R5 LJ after first fall", ovfl_oe, 1);
    @(ev_rise); chk(lat_r == 1, "R2 right latched", lat_r, 1);
    repeat (3) @(ev_rise);
    chk(lat_r == 1, "R4 held before limit", lat_r, 1);
    chk(lat_l == 0, "R6 left untouched", lat_l, 0);
    @(ev_rise); chk(lat_r == 0, "R4 cleared single", lat_r, 0);

    // B: restart by the other channel
    @(ev_rise); repeat (3) @(negedge clk); pulse(1, 0);
    repeat (3) @(ev_rise); repeat (3) @(negedge clk); pulse(0, 1);
    repeat (2) @(ev_rise); @(ev_fall);
    chk(lat_l == 1, "R3 left held by restart", lat_l, 1);
    repeat (2) @(ev_rise); @(ev_fall);
    chk(lat_l == 0, "R4 left cleared after restart", lat_l, 0);

    // C: I2S, quad speed, left channel
    restart(1, 2'd2);
    @(ev_rise); repeat (3) @(negedge clk); pulse(1, 0);
    @(ev_fall); repeat (8) @(negedge clk);
    chk(ovfl_oe == 0, "R5 I2S before second fall", ovfl_oe, 0);
    @(negedge clk);
    chk(ovfl_oe == 1, "R5 I2S after second fall", ovfl_oe, 1);
    @(ev_rise); chk(lat_l == 1, "R6 I2S left on rise", lat_l, 1);
    @(ev_fall); chk(lat_r == 0, "R6 I2S right clear", lat_r, 0);
    repeat (15) @(ev_rise); chk(lat_l == 1, "R4 quad held", lat_l, 1);
    @(ev_rise); chk(lat_l == 0, "R4 quad cleared", lat_l, 0);

    // D: left-justified, double speed, both channels
    restart(0, 2'd1);
    @(ev_rise); repeat (3) @(negedge clk); pulse(1, 1);
    repeat (7) @(ev_rise); @(ev_fall);
    chk(lat_l == 1, "R4 double held", lat_l, 1);
    chk(lat_r == 1, "R2 both channels", lat_r, 1);
    @(ev_rise); @(ev_fall);
    chk(lat_l == 0, "R4 double cleared", lat_l, 0);

    // E: I2S, code 3 behaves as quad, right channel
    restart(1, 2'd3);
    @(ev_rise); repeat (3) @(negedge clk); pulse(0, 1);
    repeat (15) @(ev_rise); @(ev_fall);
    chk(lat_r == 1, "R4 code3 held", lat_r, 1);
    @(ev_rise); @(ev_fall);
    chk(lat_r == 0, "R4 code3 cleared", lat_r, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule